// File: doc/BRIEF.md
# Macro-op aware fetch controller

This block makes the per-cycle decision for an instruction fetch stage whose instructions may expand into several micro-ops. It keeps one cache line of instruction words, tagged with its block-aligned address. Each cycle it does one of four things. It asks the instruction cache for a line, stalls, waits for a pending line, or places up to a fetch-width number of instructions and micro-ops into the decode slots.

Micro-ops come from an external sequencer. The sequencer reports how many micro-ops of the current macro-op are still left, presents the next few of them, and marks each one that is delayed-commit. While any micro-op remains, the controller does not request the next line. A fault on that line therefore cannot be charged to the running macro-op. An external interrupt is held off while the most recently issued slot was delayed-commit.

Top module: `mop_fetch_ctrl`

## Requirements
- R1: `req_valid_o` is high only when all of these hold: the line buffer misses the fetch block, `rom_i` is low, `mop_left_i` is zero, no request is outstanding and no redirect is present. After a request is accepted, no new request is made until the response arrives.
- R2: `req_addr_o` is the fetch address with its low log2(line bytes) bits cleared. The buffer hit test compares this same block address with the buffer tag.
- R3: `halt_i` always stalls issue for the cycle. `irq_i` stalls issue only when the last slot issued before this cycle was not delayed-commit. A request that is due takes precedence over both.
- R4: The delayed-commit flag takes its value from each placed slot. For a buffer word the flag is bit IW-2; for a micro-op in slot k it is `mop_dc_i[k]`. The last placed slot of the cycle wins, and reset clears the flag.
- R5: `stall_cnt_o` increments by one in each cycle stalled by `halt_i` or `irq_i`. No slot is valid in such a cycle. Reset clears the counter.
- R6: While issuing, the block fills slots in order. Remaining micro-ops go first, taken from `mop_uop_i[0..]`, and `mop_take_o` equals the number taken. Buffer words follow from the fetch offset. At most FW slots are filled, and the valid bits always form a low-order prefix.
- R7: A buffer word with bit IW-1 set is a macro-op. It goes to `mop_start_o`/`mop_inst_o` and not to decode. The fetch address steps past it, and issue ends for the cycle.
- R8: A buffer word with bit IW-3 set is a predicted-taken branch. It is issued, and issue ends for the cycle after it.
- R9: Issue ends when the offset reaches the end of the line. The fetch address then points at the next block, and the following cycle requests that block.
- R10: When `redir_i` is high, the fetch address is loaded from `redir_pc_i`. Nothing is issued and nothing is requested in that cycle.
- R11: A response (`rsp_valid_i` while a request is outstanding) fills the buffer with the tag of the accepted request. Words become issuable on the next cycle.
- R12: After reset the fetch address is RST_PC, the buffer is empty, no request is outstanding and no slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_i | input | 1 | Load a new fetch address |
| redir_pc_i | input | AW | New fetch address |
| halt_i | input | 1 | Thread switched out: stall |
| irq_i | input | 1 | External interrupt pending |
| rom_i | input | 1 | Fetch is served by the microcode ROM |
| req_valid_o | output | 1 | Cache line request |
| req_addr_o | output | AW | Block-aligned request address |
| req_ready_i | input | 1 | Cache accepts the request |
| rsp_valid_i | input | 1 | Line data returned |
| rsp_line_i | input | NI*IW | Returned line, word 0 in the low bits |
| mop_left_i | input | LW | Micro-ops still to issue |
| mop_uop_i | input | FW*IW | Next micro-ops, oldest in the low bits |
| mop_dc_i | input | FW | Delayed-commit mark per presented micro-op |
| mop_take_o | output | LW | Micro-ops consumed this cycle |
| mop_start_o | output | 1 | Macro-op word handed to the sequencer |
| mop_inst_o | output | IW | The macro-op word |
| dec_valid_o | output | FW | Per-slot valid |
| dec_uop_o | output | FW | Slot holds a micro-op |
| dec_word_o | output | FW*IW | Slot contents |
| stall_cnt_o | output | SCW | Miscellaneous stall counter |

## Verification
A wrong delayed-commit flag shows up in the very next cycle that has `irq_i` high. The decode slots either fill when they should stay empty or stay empty while `stall_cnt_o` moves. A bad buffer tag or fetch offset shows up at once, as a wrong first slot word or a spurious `req_valid_o`. A request made during a running macro-op shows up in the same cycle at `req_valid_o`. The bench therefore places interrupts right after delayed and plain slots, and ends a line on a macro-op whose micro-ops must drain before the next request appears.

// File: rtl/mop_fetch_ctrl.sv
module mop_fetch_ctrl #(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int NI = 8,
  parameter int FW = 4,
  parameter int LW = 4,
  parameter int SCW = 16,
  parameter logic [AW-1:0] RST_PC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     redir_i,
  input  logic [AW-1:0]            redir_pc_i,
  input  logic                     halt_i,
  input  logic                     irq_i,
  input  logic                     rom_i,
  output logic                     req_valid_o,
  output logic [AW-1:0]            req_addr_o,
  input  logic                     req_ready_i,
  input  logic                     rsp_valid_i,
  input  logic [NI-1:0][IW-1:0]    rsp_line_i,
  input  logic [LW-1:0]            mop_left_i,
  input  logic [FW-1:0][IW-1:0]    mop_uop_i,
  input  logic [FW-1:0]            mop_dc_i,
  output logic [LW-1:0]            mop_take_o,
  output logic                     mop_start_o,
  output logic [IW-1:0]            mop_inst_o,
  output logic [FW-1:0]            dec_valid_o,
  output logic [FW-1:0]            dec_uop_o,
  output logic [FW-1:0][IW-1:0]    dec_word_o,
  output logic [SCW-1:0]           stall_cnt_o
);
  localparam int ISZ  = IW / 8;
  localparam int IB   = $clog2(ISZ);
  localparam int OFFB = $clog2(NI * ISZ);
  localparam int TW   = AW - OFFB;

  logic [AW-1:0]         pc_q, pc_n;
  logic                  buf_v_q, pend_q, dc_q, dc_n, stop;
  logic [TW-1:0]         buf_tag_q, req_tag_q;
  logic [NI-1:0][IW-1:0] buf_q;
  logic [SCW-1:0]        stall_q;
  logic [IW-1:0]         wd;
  int                    o, o0, t;

  wire [TW-1:0] blk_tag  = pc_q[AW-1:OFFB];
  wire          hit      = buf_v_q && (buf_tag_q == blk_tag);
  wire          need_req = !hit && !rom_i && (mop_left_i == '0);
  wire          irq_hold = irq_i && !dc_q;
  wire          do_req   = !redir_i && need_req && !pend_q;
  wire          do_stall = !redir_i && !need_req && (halt_i || irq_hold);
  wire          do_issue = !redir_i && !need_req && !halt_i && !irq_hold;

  assign req_valid_o = do_req;
  assign req_addr_o  = {blk_tag, {OFFB{1'b0}}};
  assign stall_cnt_o = stall_q;

  always_comb begin
    dec_valid_o = '0;
    dec_uop_o   = '0;
    dec_word_o  = '0;
    mop_start_o = 1'b0;
    mop_inst_o  = '0;
    dc_n = dc_q;
    stop = 1'b0;
    wd   = '0;
    o0   = int'(pc_q[OFFB-1:IB]);
    o    = o0;
    t    = 0;
    for (int k = 0; k < FW; k++) begin
      if (do_issue && !stop) begin
        if (t < int'(mop_left_i)) begin
          dec_valid_o[k] = 1'b1;
          dec_uop_o[k]   = 1'b1;
          dec_word_o[k]  = mop_uop_i[t];
          dc_n = mop_dc_i[t];
          t = t + 1;
        end else if (hit && o < NI) begin
          wd = buf_q[o];
          o  = o + 1;
          if (wd[IW-1]) begin
            mop_start_o = 1'b1;
            mop_inst_o  = wd;
            stop = 1'b1;
          end else begin
            dec_valid_o[k] = 1'b1;
            dec_word_o[k]  = wd;
            dc_n = wd[IW-2];
            if (wd[IW-3]) stop = 1'b1;
          end
        end else begin
          stop = 1'b1;
        end
      end
    end
    mop_take_o = LW'(t);
    pc_n = pc_q + AW'((o - o0) * ISZ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= RST_PC;
      buf_v_q   <= 1'b0;
      pend_q    <= 1'b0;
      dc_q      <= 1'b0;
      buf_tag_q <= '0;
      req_tag_q <= '0;
      stall_q   <= '0;
    end else begin
      if (redir_i) pc_q <= redir_pc_i;
      else if (do_issue) pc_q <= pc_n;
      if (rsp_valid_i && pend_q) begin
        pend_q    <= 1'b0;
        buf_v_q   <= 1'b1;
        buf_tag_q <= req_tag_q;
      end else if (do_req && req_ready_i) begin
        pend_q    <= 1'b1;
        req_tag_q <= blk_tag;
      end
      if (do_issue) dc_q <= dc_n;
      if (do_stall) stall_q <= stall_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_i && pend_q) buf_q <= rsp_line_i;
  end

  logic chk_dc, chk_flag;
  always_comb begin
    chk_flag = chk_dc;
    for (int k = 0; k < FW; k++)
      if (dec_valid_o[k]) chk_flag = dec_uop_o[k] ? mop_dc_i[k] : dec_word_o[k][IW-2];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_dc <= 1'b0;
    else if (|dec_valid_o) chk_dc <= chk_flag;
  end

  a_r1_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (mop_left_i == '0 && !rom_i && !redir_i));
  a_r1_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> !req_valid_o);
  a_r3_halt_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |-> dec_valid_o == '0);
  a_r4_irq_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && |dec_valid_o) |-> chk_dc);
  a_r5_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|dec_valid_o) |=> stall_cnt_o == $past(stall_cnt_o));
  a_r6_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec_valid_o + 1'b1) & dec_valid_o) == '0);
  a_r6_take_count: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mop_take_o) == $countones(dec_uop_o) && mop_take_o <= mop_left_i);
  a_r7_start_after_uops: assert property (@(posedge clk) disable iff (!rst_n)
    mop_start_o |-> mop_take_o == mop_left_i);
  a_r10_redir_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    redir_i |-> (dec_valid_o == '0 && !req_valid_o && !mop_start_o));
endmodule

// File: tb/mop_fetch_ctrl_tb_top.sv
module mop_fetch_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic redir_i, halt_i, irq_i, rom_i, req_ready_i, rsp_valid_i;
  logic [31:0] redir_pc_i;
  logic req_valid_o, mop_start_o;
  logic [31:0] req_addr_o;
  logic [7:0][15:0] rsp_line_i;
  logic [3:0] mop_left_i, mop_dc_i, mop_take_o, dec_valid_o, dec_uop_o;
  logic [3:0][15:0] mop_uop_i, dec_word_o;
  logic [15:0] mop_inst_o, stall_cnt_o;

  mop_fetch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .redir_i(redir_i), .redir_pc_i(redir_pc_i),
    .halt_i(halt_i), .irq_i(irq_i), .rom_i(rom_i),
    .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_line_i(rsp_line_i),
    .mop_left_i(mop_left_i), .mop_uop_i(mop_uop_i), .mop_dc_i(mop_dc_i),
    .mop_take_o(mop_take_o), .mop_start_o(mop_start_o), .mop_inst_o(mop_inst_o),
    .dec_valid_o(dec_valid_o), .dec_uop_o(dec_uop_o), .dec_word_o(dec_word_o),
    .stall_cnt_o(stall_cnt_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  left;
    logic [3:0]  dcm;
    logic        irq;
    logic        rom;
    logic [3:0]  ev;
    logic [3:0]  eu;
    logic [3:0]  etake;
    logic        est;
    logic        erq;
    logic [15:0] estall;
    logic [15:0] ew0;
    logic [15:0] einst;
  } vec_t;

  // line at 0x10: plain, delayed, delayed+taken branch, plain, macro, plain, plain, macro
  localparam vec_t VEC [10] = '{
    '{4'd0, 4'b0000, 1'b0, 1'b0, 4'b0111, 4'b0000, 4'd0, 1'b0, 1'b0, 16'd0, 16'h0200, 16'h0000}, // R8 branch ends issue
    '{4'd0, 4'b0000, 1'b1, 1'b0, 4'b0001, 4'b0000, 4'd0, 1'b1, 1'b0, 16'd0, 16'h0203, 16'h8204}, // R4 irq deferred, R7
    '{4'd0, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'd0, 1'b0, 1'b0, 16'd0, 16'h0000, 16'h0000}, // R3 irq stall
    '{4'd3, 4'b0000, 1'b0, 1'b0, 4'b1111, 4'b0111, 4'd3, 1'b0, 1'b0, 16'd1, 16'h1A00, 16'h0000}, // R6 uops then words
    '{4'd0, 4'b0000, 1'b0, 1'b0, 4'b0001, 4'b0000, 4'd0, 1'b1, 1'b0, 16'd1, 16'h0206, 16'h8207}, // R7 macro at line end
    '{4'd5, 4'b1000, 1'b0, 1'b0, 4'b1111, 4'b1111, 4'd4, 1'b0, 1'b0, 16'd1, 16'h1A00, 16'h0000}, // R1 no request mid macro
    '{4'd1, 4'b0000, 1'b1, 1'b0, 4'b0001, 4'b0001, 4'd1, 1'b0, 1'b0, 16'd1, 16'h1A00, 16'h0000}, // R4 uop flag defers irq
    '{4'd0, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'd0, 1'b0, 1'b1, 16'd1, 16'h0000, 16'h0000}, // R3 request first
    '{4'd0, 4'b0000, 1'b1, 1'b1, 4'b0000, 4'b0000, 4'd0, 1'b0, 1'b0, 16'd1, 16'h0000, 16'h0000}, // R1 rom gates, R3 stall
    '{4'd0, 4'b0000, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'd0, 1'b0, 1'b1, 16'd2, 16'h0000, 16'h0000}  // R5 count held
  };

  function automatic logic [7:0][15:0] plain_line(input logic [15:0] base);
    logic [7:0][15:0] l;
    for (int i = 0; i < 8; i++) l[i] = base + 16'(i);
    return l;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    redir_i = 0; redir_pc_i = '0; halt_i = 0; irq_i = 0; rom_i = 0;
    req_ready_i = 0; rsp_valid_i = 0; rsp_line_i = '0;
    mop_left_i = '0; mop_dc_i = '0;
    for (int k = 0; k < 4; k++) mop_uop_i[k] = 16'h1A00 + 16'(k);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    req_ready_i = 1; #1;
    check(dec_valid_o == 0, "R12 no valid after reset", 32'(dec_valid_o), 0);
    check(stall_cnt_o == 0, "R12/R5 counter cleared", 32'(stall_cnt_o), 0);
    check(req_valid_o == 1, "R12/R1 empty buffer requests", 32'(req_valid_o), 1);
    check(req_addr_o == 32'h0, "R2 reset address", req_addr_o, 0);
    @(negedge clk) req_ready_i = 0; #1;
    check(req_valid_o == 0, "R1 one outstanding", 32'(req_valid_o), 0);
    @(negedge clk) rsp_valid_i = 1; rsp_line_i = plain_line(16'h0100); #1;
    check(dec_valid_o == 0, "R11 data not usable yet", 32'(dec_valid_o), 0);
    @(negedge clk) rsp_valid_i = 0; #1;
    check(dec_valid_o == 4'hF && dec_word_o[0] == 16'h0100 && dec_word_o[3] == 16'h0103,
          "R11/R6 first group", 32'(dec_word_o[3]), 32'h0103);
    @(negedge clk); #1;
    check(dec_valid_o == 4'hF && dec_word_o[0] == 16'h0104, "R6 second group", 32'(dec_word_o[0]), 32'h0104);
    @(negedge clk) req_ready_i = 1; #1;
    check(req_valid_o && req_addr_o == 32'h10, "R9 next block request", req_addr_o, 32'h10);
    @(negedge clk) req_ready_i = 0; rsp_valid_i = 1;
    rsp_line_i = '{16'h8207, 16'h0206, 16'h0205, 16'h8204, 16'h0203, 16'h6202, 16'h4201, 16'h0200}; #1;
    check(dec_valid_o == 0, "R11 fill cycle idle", 32'(dec_valid_o), 0);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rsp_valid_i = 0;
      mop_left_i = VEC[i].left; mop_dc_i = VEC[i].dcm; irq_i = VEC[i].irq; rom_i = VEC[i].rom;
      #1;
      check(dec_valid_o == VEC[i].ev, "R6 valid slots", 32'(dec_valid_o), 32'(VEC[i].ev));
      check(dec_uop_o == VEC[i].eu && mop_take_o == VEC[i].etake, "R6 micro-op take",
            32'(mop_take_o), 32'(VEC[i].etake));
      if (VEC[i].ev[0])
        check(dec_word_o[0] == VEC[i].ew0, "R6 first slot word", 32'(dec_word_o[0]), 32'(VEC[i].ew0));
      check(mop_start_o == VEC[i].est, "R7 macro hand-off", 32'(mop_start_o), 32'(VEC[i].est));
      if (VEC[i].est)
        check(mop_inst_o == VEC[i].einst, "R7 macro word", 32'(mop_inst_o), 32'(VEC[i].einst));
      check(req_valid_o == VEC[i].erq, "R1 request gating", 32'(req_valid_o), 32'(VEC[i].erq));
      if (VEC[i].erq)
        check(req_addr_o == 32'h20, "R2 request address", req_addr_o, 32'h20);
      check(stall_cnt_o == VEC[i].estall, "R3/R5 stall count", 32'(stall_cnt_o), 32'(VEC[i].estall));
    end

    @(negedge clk) mop_left_i = 0; mop_dc_i = 0; irq_i = 0; rom_i = 0; req_ready_i = 1; #1;
    check(req_valid_o && req_addr_o == 32'h20, "R1 request after macro drains", req_addr_o, 32'h20);
    @(negedge clk) req_ready_i = 0; rsp_valid_i = 1; rsp_line_i = plain_line(16'h0300); #1;
    @(negedge clk) rsp_valid_i = 0; halt_i = 1; #1;
    check(dec_valid_o == 0, "R3 halt stalls", 32'(dec_valid_o), 0);
    @(negedge clk) halt_i = 0; #1;
    check(stall_cnt_o == 16'd3, "R5 halt counted", 32'(stall_cnt_o), 3);
    check(dec_valid_o == 4'hF && dec_word_o[0] == 16'h0300, "R6 resume after halt", 32'(dec_word_o[0]), 32'h0300);
    @(negedge clk) redir_i = 1; redir_pc_i = 32'h26; #1;
    check(dec_valid_o == 0 && !req_valid_o, "R10 redirect cycle quiet", 32'(dec_valid_o), 0);
    @(negedge clk) redir_i = 0; #1;
    check(dec_valid_o == 4'hF && dec_word_o[0] == 16'h0303 && dec_word_o[3] == 16'h0306,
          "R10 issue from new address", 32'(dec_word_o[0]), 32'h0303);
    @(negedge clk); #1;
    check(dec_valid_o == 4'b0001 && dec_word_o[0] == 16'h0307, "R9 stop at line end", 32'(dec_valid_o), 1);
    @(negedge clk); #1;
    check(req_valid_o && req_addr_o == 32'h30, "R9 following block", req_addr_o, 32'h30);
    @(negedge clk) redir_i = 1; redir_pc_i = 32'h1C; #1;
    @(negedge clk) redir_i = 0; #1;
    check(req_valid_o && req_addr_o == 32'h10, "R2 aligned down", req_addr_o, 32'h10);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule